// File: doc/BRIEF.md
# Operand Forwarding Select Unit

This block chooses, for each of the two ALU operands in the execute stage of a five-stage pipeline, where the operand value comes from. There are three possible sources. The first is the value read from the register file and held in the decode/execute register. The second is the ALU result that sits in the execute/memory register. The third is the final value in the memory/writeback register. The block compares each source register number against the destination and write enable of the two later stages. From that comparison it produces a 2-bit select for each operand and drives the selected 32-bit value onto the operand outputs.

When both later stages hold a pending write to the same source register, the younger result in execute/memory wins. Register 0 is hard-wired and is never forwarded. A stage whose write enable is low never forwards. That covers bubbles and stores, even when their destination field happens to match.

By default the selects and operand values are registered once (parameter `OUT_REG`), so they appear one clock after the inputs. With `OUT_REG = 0` the path is purely combinational and clock and reset are unused.

Top module: `fwd_unit`

## Requirements
- R1: When the execute/memory write enable is 1, its destination is nonzero and equals an operand's source register, that operand's select is 2'b10 and its value is the execute/memory result.
- R2: When the memory/writeback write enable is 1, its destination is nonzero and equals an operand's source register, and R1 does not hold for that operand, the select is 2'b01 and the value is the memory/writeback result.
- R3: When both later stages satisfy their forwarding conditions for the same operand, the execute/memory result is chosen (select 2'b10).
- R4: A destination of register 0 never causes forwarding, whatever the write enables.
- R5: A stage with write enable 0 never causes forwarding, even when its destination matches.
- R6: When neither condition holds, the select is 2'b00 and the operand is the decode/execute value unchanged.
- R7: Operand A and operand B are decided independently from their own source fields.
- R8: With `OUT_REG = 1`, selects and operands appear one clock after the inputs. While `rst_n` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low synchronous reset of the output register |
| dx_src_a | input | 5 | Source register number of operand A (decode/execute) |
| dx_src_b | input | 5 | Source register number of operand B (decode/execute) |
| dx_val_a | input | 32 | Register-file value of operand A |
| dx_val_b | input | 32 | Register-file value of operand B |
| xm_dst | input | 5 | Destination register in execute/memory |
| xm_wen | input | 1 | Register write enable in execute/memory |
| xm_res | input | 32 | ALU result held in execute/memory |
| mw_dst | input | 5 | Destination register in memory/writeback |
| mw_wen | input | 1 | Register write enable in memory/writeback |
| mw_res | input | 32 | Final writeback value in memory/writeback |
| sel_a | output | 2 | Source select of operand A (00 file, 10 ex/mem, 01 mem/wb) |
| sel_b | output | 2 | Source select of operand B |
| opnd_a | output | 32 | Selected operand A value |
| opnd_b | output | 32 | Selected operand B value |

## Verification
The bench goes after the case where both stages target the same source. A design with the priority reversed would hand over the stale writeback value instead of the newer ALU result. It drives register-0 destinations with the write enables set, where a missing zero check would forward a result that must read as zero. It also drives matching destinations with the write enable cleared, which a design ignoring the enable would forward from a bubble or a store. Random patterns over a small register range then hit single-operand and both-operand matches often, which exposes any crossing of the A and B paths.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

    typedef enum logic [1:0] {
        SRC_FILE = 2'b00,
        SRC_MWB  = 2'b01,
        SRC_XM   = 2'b10
    } src_sel_e;

endpackage

// File: rtl/fwd_match.sv
module fwd_match
    import fwd_pkg::*;
#(
    parameter int REG_W = 5
) (
    input  logic [REG_W-1:0] src,
    input  logic [REG_W-1:0] xm_dst,
    input  logic             xm_wen,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wen,
    output src_sel_e         sel
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic xm_hit;
    logic mw_hit;

    always_comb begin
        xm_hit = xm_wen && (xm_dst != ZERO_REG) && (xm_dst == src);
        mw_hit = mw_wen && (mw_dst != ZERO_REG) && (mw_dst == src);
        if (xm_hit) begin
            sel = SRC_XM;
        end else if (mw_hit) begin
            sel = SRC_MWB;
        end else begin
            sel = SRC_FILE;
        end
    end

    always_comb begin
        AST_ZERO_SRC_LOCAL: assert (!(src == ZERO_REG && sel != SRC_FILE)); // R4
    end

endmodule

// File: rtl/fwd_opmux.sv
module fwd_opmux
    import fwd_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  src_sel_e        sel,
    input  logic [XLEN-1:0] file_val,
    input  logic [XLEN-1:0] xm_val,
    input  logic [XLEN-1:0] mw_val,
    output logic [XLEN-1:0] out_val
);
    always_comb begin
        unique case (sel)
            SRC_XM:  out_val = xm_val;
            SRC_MWB: out_val = mw_val;
            default: out_val = file_val;
        endcase
    end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
    import fwd_pkg::*;
#(
    parameter int XLEN    = 32,
    parameter int REG_W   = 5,
    parameter bit OUT_REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [REG_W-1:0] dx_src_a,
    input  logic [REG_W-1:0] dx_src_b,
    input  logic [XLEN-1:0]  dx_val_a,
    input  logic [XLEN-1:0]  dx_val_b,
    input  logic [REG_W-1:0] xm_dst,
    input  logic             xm_wen,
    input  logic [XLEN-1:0]  xm_res,
    input  logic [REG_W-1:0] mw_dst,
    input  logic             mw_wen,
    input  logic [XLEN-1:0]  mw_res,
    output logic [1:0]       sel_a,
    output logic [1:0]       sel_b,
    output logic [XLEN-1:0]  opnd_a,
    output logic [XLEN-1:0]  opnd_b
);
    localparam int NUM_OPS = 2;

    logic [NUM_OPS-1:0][REG_W-1:0] src_v;
    logic [NUM_OPS-1:0][XLEN-1:0]  file_v;
    src_sel_e                      sel_v [NUM_OPS];
    logic [NUM_OPS-1:0][XLEN-1:0]  val_v;

    assign src_v[0]  = dx_src_a;
    assign src_v[1]  = dx_src_b;
    assign file_v[0] = dx_val_a;
    assign file_v[1] = dx_val_b;

    for (genvar i = 0; i < NUM_OPS; i++) begin : g_op
        fwd_match #(.REG_W(REG_W)) u_match (
            .src    (src_v[i]),
            .xm_dst (xm_dst),
            .xm_wen (xm_wen),
            .mw_dst (mw_dst),
            .mw_wen (mw_wen),
            .sel    (sel_v[i])
        );
        fwd_opmux #(.XLEN(XLEN)) u_mux (
            .sel      (sel_v[i]),
            .file_val (file_v[i]),
            .xm_val   (xm_res),
            .mw_val   (mw_res),
            .out_val  (val_v[i])
        );
    end

    if (OUT_REG) begin : g_reg
        logic [1:0]      sel_a_q, sel_b_q;
        logic [XLEN-1:0] opnd_a_q, opnd_b_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_a_q  <= '0;
                sel_b_q  <= '0;
                opnd_a_q <= '0;
                opnd_b_q <= '0;
            end else begin
                sel_a_q  <= sel_v[0];
                sel_b_q  <= sel_v[1];
                opnd_a_q <= val_v[0];
                opnd_b_q <= val_v[1];
            end
        end

        assign sel_a  = sel_a_q;
        assign sel_b  = sel_b_q;
        assign opnd_a = opnd_a_q;
        assign opnd_b = opnd_b_q;

        AST_XM_FWD_A: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(xm_wen && xm_dst != '0 && xm_dst == dx_src_a))
            |-> (sel_a == 2'b10 && opnd_a == $past(xm_res))); // R1
        AST_MWB_FWD_B: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(mw_wen && mw_dst != '0 && mw_dst == dx_src_b
                && !(xm_wen && xm_dst != '0 && xm_dst == dx_src_b)))
            |-> (sel_b == 2'b01 && opnd_b == $past(mw_res))); // R2
        AST_NO_ZERO_FWD: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(dx_src_a == '0)) |-> (sel_a == 2'b00)); // R4
        AST_WEN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $past(!xm_wen && !mw_wen))
            |-> (sel_a == 2'b00 && sel_b == 2'b00)); // R5
        AST_PASS_THRU: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && sel_a == 2'b00) |-> (opnd_a == $past(dx_val_a))); // R6
        AST_RESET_CLEAR: assert property (@(posedge clk)
            $past(!rst_n) |-> (sel_a == 2'b00 && sel_b == 2'b00 && opnd_a == '0)); // R8
    end else begin : g_comb
        assign sel_a  = sel_v[0];
        assign sel_b  = sel_v[1];
        assign opnd_a = val_v[0];
        assign opnd_b = val_v[1];
    end

endmodule

// File: tb/sim_fwd_unit.sv
module sim_fwd_unit;
    localparam int XLEN  = 32;
    localparam int REG_W = 5;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [REG_W-1:0] dx_src_a = '0, dx_src_b = '0, xm_dst = '0, mw_dst = '0;
    logic [XLEN-1:0]  dx_val_a = '0, dx_val_b = '0, xm_res = '0, mw_res = '0;
    logic             xm_wen = 1'b0, mw_wen = 1'b0;
    logic [1:0]       sel_a, sel_b;
    logic [XLEN-1:0]  opnd_a, opnd_b;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    fwd_unit #(.XLEN(XLEN), .REG_W(REG_W), .OUT_REG(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n),
        .dx_src_a(dx_src_a), .dx_src_b(dx_src_b),
        .dx_val_a(dx_val_a), .dx_val_b(dx_val_b),
        .xm_dst(xm_dst), .xm_wen(xm_wen), .xm_res(xm_res),
        .mw_dst(mw_dst), .mw_wen(mw_wen), .mw_res(mw_res),
        .sel_a(sel_a), .sel_b(sel_b), .opnd_a(opnd_a), .opnd_b(opnd_b)
    );

    function automatic logic [1:0] exp_sel(input logic [REG_W-1:0] s);
        if (xm_wen && xm_dst != 0 && xm_dst == s) return 2'b10;
        if (mw_wen && mw_dst != 0 && mw_dst == s) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic [XLEN-1:0] exp_val(input logic [1:0] s, input logic [XLEN-1:0] f);
        if (s == 2'b10) return xm_res;
        if (s == 2'b01) return mw_res;
        return f;
    endfunction

    task automatic chk(input string req, input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive at negedge, registered output sampled at the next negedge
    task automatic apply(input string req,
                         input logic [REG_W-1:0] sa, input logic [REG_W-1:0] sb,
                         input logic [REG_W-1:0] xd, input logic xw,
                         input logic [REG_W-1:0] md, input logic mw);
        logic [1:0]      es_a, es_b;
        logic [XLEN-1:0] ev_a, ev_b;
        @(negedge clk);
        dx_src_a = sa; dx_src_b = sb;
        xm_dst = xd; xm_wen = xw; mw_dst = md; mw_wen = mw;
        dx_val_a = $urandom; dx_val_b = $urandom;
        xm_res = $urandom; mw_res = $urandom;
        es_a = exp_sel(sa); es_b = exp_sel(sb);
        ev_a = exp_val(es_a, dx_val_a); ev_b = exp_val(es_b, dx_val_b);
        @(negedge clk);
        chk({req, " sel_a"}, XLEN'(sel_a), XLEN'(es_a));
        chk({req, " sel_b"}, XLEN'(sel_b), XLEN'(es_b));
        chk({req, " opnd_a"}, opnd_a, ev_a);
        chk({req, " opnd_b"}, opnd_b, ev_b);
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1A2B3C4D));
        xm_wen = 1'b1; xm_dst = 5'd3; dx_src_a = 5'd3;
        repeat (3) @(negedge clk);
        // R8: reset clears outputs despite a matching input
        chk("R8 reset sel_a", XLEN'(sel_a), '0);
        chk("R8 reset opnd_a", opnd_a, '0);
        rst_n = 1'b1;

        apply("R1 xm fwd A", 5'd7, 5'd9, 5'd7, 1'b1, 5'd12, 1'b1);
        apply("R2 mw fwd B", 5'd4, 5'd12, 5'd7, 1'b1, 5'd12, 1'b1);
        apply("R3 priority both", 5'd5, 5'd5, 5'd5, 1'b1, 5'd5, 1'b1);
        apply("R4 zero dest", 5'd0, 5'd0, 5'd0, 1'b1, 5'd0, 1'b1);
        apply("R5 wen low", 5'd8, 5'd8, 5'd8, 1'b0, 5'd8, 1'b0);
        apply("R5 xm off mw on", 5'd8, 5'd2, 5'd8, 1'b0, 5'd8, 1'b1);
        apply("R6 no match", 5'd1, 5'd2, 5'd3, 1'b1, 5'd4, 1'b1);
        apply("R7 split A xm B mw", 5'd10, 5'd11, 5'd10, 1'b1, 5'd11, 1'b1);

        for (int n = 0; n < 400; n++) begin
            apply("R7 random", 5'($urandom_range(0, 3)), 5'($urandom_range(0, 3)),
                  5'($urandom_range(0, 3)), 1'($urandom),
                  5'($urandom_range(0, 3)), 1'($urandom));
        end

        // R8: one-cycle latency, value must not appear before the edge
        @(negedge clk);
        dx_src_a = 5'd6; xm_dst = 5'd6; xm_wen = 1'b1; mw_wen = 1'b0;
        xm_res = 32'hDEAD_BEEF; dx_val_a = 32'h1111_1111;
        #1;
        chk("R8 latency before edge", XLEN'(sel_a == 2'b10 && opnd_a == 32'hDEAD_BEEF), '0);
        @(negedge clk);
        chk("R8 latency after edge", opnd_a, 32'hDEAD_BEEF);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule